// File: doc/BRIEF.md
# Digital Downconverter with CIC Decimator

This block takes a stream of complex samples, one per accepted beat, and translates it down in frequency by multiplying each sample with the conjugate of a locally generated complex oscillator. A 32-bit phase accumulator drives a quarter-wave cosine table to produce that oscillator. The full-precision product goes through a programmable bit-select quantizer. A three-stage CIC filter then reduces the sample rate by a programmable ratio, and a second quantizer follows the CIC.

Two selects choose what reaches the output. The source select picks the mixer product, the raw oscillator, or the input passed through unchanged. The CIC select either filters and decimates that stream or passes it at full rate. The control inputs are static configuration lines and are normally driven from a register file. The phase increment is the exception: it is captured only on a write strobe.

Top module: `ddc_core`

## Requirements
- R1: While reset is asserted and directly after it, `m_tvalid` is 0 and `s_tready` is 1. The phase accumulator and the active phase increment both start at 0.
- R2: Both stream words carry I in bits [15:0] and Q in bits [31:16], as signed 16-bit values. With `src_sel` = 2 or 3 and the CIC bypassed, each input sample appears unchanged on the output.
- R3: With `src_sel` = 1, the output is the oscillator itself: I = cos, Q = sin, full scale 32767. At phases of 0, 1/4, 1/2 and 3/4 turn it is exactly (32767,0), (0,32767), (-32767,0) and (0,-32767).
- R4: The phase accumulator is 32 bits wide. It advances by the active increment once for every accepted input beat. Sample n uses the phase that is the sum of the increments applied before it, whatever `src_sel` is.
- R5: `pinc` becomes the active increment only on a high-to-low transition of `pinc_we`. A new `pinc` value with `pinc_we` low, or with `pinc_we` held high, does not change the oscillator.
- R6: With `src_sel` = 0, the output is the quantized product (I + jQ)(C - jS). The real part is I*C + Q*S and the imaginary part is Q*C - I*S, where C and S are the oscillator cosine and sine.
- R7: The product quantizer shifts the product arithmetically right by `prod_shift` and saturates the result to [-32768, 32767]. Shift values above 16 act as 16.
- R8: With `cic_bypass` = 1, every input produces exactly one output. The decimation counter and all CIC state are held at zero.
- R9: With `cic_bypass` = 0, one output is produced for every D accepted inputs, so N inputs after a clear give floor(N/D) outputs. D is `dec_ratio` limited to the range 2 to 1000.
- R10: For a constant input x, the settled CIC output is floor(x*D^3 / 2^`cic_shift`), saturated to 16 bits. Shift values above 30 act as 30.
- R11: While `m_tvalid` is 1 and `m_tready` is 0, `m_tdata` holds and `s_tready` is 0. No sample is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pinc | input | 32 | Phase increment, captured when the strobe falls |
| pinc_we | input | 1 | Phase increment write strobe |
| src_sel | input | 2 | 0 product, 1 oscillator, 2 or 3 input |
| cic_bypass | input | 1 | 1 skips the CIC and decimation |
| prod_shift | input | 5 | Product quantizer shift, 0 to 16 |
| cic_shift | input | 5 | CIC quantizer shift, 0 to 30 |
| dec_ratio | input | 10 | Decimation ratio, 2 to 1000 |
| s_tvalid | input | 1 | Input sample valid |
| s_tready | output | 1 | Input sample accepted |
| s_tdata | input | 32 | Input sample {Q, I} |
| m_tvalid | output | 1 | Output sample valid |
| m_tready | input | 1 | Output sample taken |
| m_tdata | output | 32 | Output sample {Q, I} |

## Verification
A wrong phase or a wrong increment shows up in the oscillator and product outputs on the very next sample. Stepping by quarter turns makes the error exact and easy to read. A wrong decimation counter changes how many outputs a burst of inputs produces, and this is visible after the first D inputs. Corrupt integrator or comb state stays hidden until the filter settles, about 3D inputs. After that it shows as a settled value that misses floor(x*D^3/2^shift).

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int SMP_W = 16;

  typedef enum logic [1:0] {
    SRC_PRODUCT = 2'd0,
    SRC_NCO     = 2'd1,
    SRC_INPUT   = 2'd2,
    SRC_INPUT_B = 2'd3
  } src_sel_e;

  typedef struct packed {
    logic signed [SMP_W-1:0] q;
    logic signed [SMP_W-1:0] i;
  } cplx_t;
endpackage

// File: rtl/ddc_quant.sv
module ddc_quant #(
  parameter int IN_W   = 33,
  parameter int OUT_W  = 16,
  parameter int SH_W   = 5,
  parameter int MAX_SH = 16
) (
  input  logic signed [IN_W-1:0]  din,
  input  logic        [SH_W-1:0]  shift,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic signed [IN_W-1:0] Q_HI = IN_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [IN_W-1:0] Q_LO = ~Q_HI;

  logic [SH_W-1:0]        sh_eff;
  logic signed [IN_W-1:0] shifted;

  always_comb begin
    sh_eff  = (shift > SH_W'(MAX_SH)) ? SH_W'(MAX_SH) : shift;
    shifted = din >>> sh_eff;
    if (shifted > Q_HI)      dout = Q_HI[OUT_W-1:0];
    else if (shifted < Q_LO) dout = Q_LO[OUT_W-1:0];
    else                     dout = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/ddc_nco.sv
module ddc_nco #(
  parameter int PH_W   = 32,
  parameter int LUT_AW = 6,
  parameter int AMP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic [PH_W-1:0]         pinc,
  input  logic                    pinc_we,
  output logic signed [AMP_W-1:0] cos_o,
  output logic signed [AMP_W-1:0] sin_o
);
  localparam int     LUT_N = 1 << LUT_AW;
  localparam longint AMP   = (64'sd1 <<< (AMP_W-1)) - 64'sd1;

  // Quarter-wave cosine, parabolic shape; exact at both ends.
  function automatic logic signed [AMP_W-1:0] qcos(input int k);
    longint v;
    v = AMP - (AMP * longint'(k) * longint'(k)) / (longint'(LUT_N) * longint'(LUT_N));
    return v[AMP_W-1:0];
  endfunction

  logic signed [AMP_W-1:0] qtab [LUT_N+1];
  for (genvar g = 0; g <= LUT_N; g++) begin : g_tab
    assign qtab[g] = qcos(g);
  end

  logic [PH_W-1:0] phase_q, phase_d;
  logic [PH_W-1:0] pinc_q, pinc_d;
  logic            we_q;

  always_comb begin
    pinc_d = pinc_q;
    if (we_q && !pinc_we) pinc_d = pinc;
    phase_d = phase_q;
    if (step) phase_d = phase_q + pinc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      pinc_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pinc_q  <= pinc_d;
      we_q    <= pinc_we;
    end
  end

  logic [1:0]              quad;
  logic [LUT_AW:0]         idx_c, idx_s;
  logic signed [AMP_W-1:0] cv, sv;

  always_comb begin
    quad  = phase_q[PH_W-1 -: 2];
    idx_c = {1'b0, phase_q[PH_W-3 -: LUT_AW]};
    idx_s = (LUT_AW+1)'(LUT_N) - idx_c;
    cv    = qtab[idx_c];
    sv    = qtab[idx_s];
    case (quad)
      2'd0:    begin cos_o = cv;  sin_o = sv;  end
      2'd1:    begin cos_o = -sv; sin_o = cv;  end
      2'd2:    begin cos_o = -cv; sin_o = -sv; end
      default: begin cos_o = sv;  sin_o = -cv; end
    endcase
  end

  AST_PINC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_q && !pinc_we) |=> $stable(pinc_q)); // R5
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(phase_q)); // R4
endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer #(
  parameter int IW = 16,
  parameter int CW = 16,
  parameter int PW = IW + CW + 1
) (
  input  logic signed [IW-1:0] in_i,
  input  logic signed [IW-1:0] in_q,
  input  logic signed [CW-1:0] lo_c,
  input  logic signed [CW-1:0] lo_s,
  output logic signed [PW-1:0] re,
  output logic signed [PW-1:0] im
);
  logic signed [IW+CW-1:0] p_ic, p_qs, p_qc, p_is;

  always_comb begin
    p_ic = in_i * lo_c;
    p_qs = in_q * lo_s;
    p_qc = in_q * lo_c;
    p_is = in_i * lo_s;
    re   = PW'(p_ic) + PW'(p_qs);
    im   = PW'(p_qc) - PW'(p_is);
  end
endmodule

// File: rtl/ddc_cic.sv
module ddc_cic #(
  parameter int SMP_W   = 16,
  parameter int STAGES  = 3,
  parameter int DEC_MIN = 2,
  parameter int DEC_MAX = 1000,
  parameter int SH_MAX  = 30,
  parameter int SH_W    = 5,
  parameter int DEC_W   = $clog2(DEC_MAX+1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    bypass,
  input  logic [DEC_W-1:0]        dec_ratio,
  input  logic [SH_W-1:0]         cic_shift,
  input  logic                    in_v,
  input  logic signed [SMP_W-1:0] in_i,
  input  logic signed [SMP_W-1:0] in_q,
  output logic                    out_v,
  output logic signed [SMP_W-1:0] out_i,
  output logic signed [SMP_W-1:0] out_q
);
  localparam int GROW  = STAGES * $clog2(DEC_MAX);
  localparam int ACC_W = SMP_W + GROW;
  localparam int LANES = 2;

  logic [DEC_W-1:0] dec_eff, cnt_q, cnt_d;
  logic             hit;

  always_comb begin
    if (dec_ratio < DEC_W'(DEC_MIN))      dec_eff = DEC_W'(DEC_MIN);
    else if (dec_ratio > DEC_W'(DEC_MAX)) dec_eff = DEC_W'(DEC_MAX);
    else                                  dec_eff = dec_ratio;
    hit   = (cnt_q >= dec_eff - 1'b1);
    cnt_d = cnt_q;
    if (bypass)            cnt_d = '0;
    else if (en && in_v)   cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  logic signed [SMP_W-1:0] lane_in  [LANES];
  logic signed [SMP_W-1:0] lane_out [LANES];
  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic signed [ACC_W-1:0] integ_q [STAGES];
    logic signed [ACC_W-1:0] integ_d [STAGES];
    logic signed [ACC_W-1:0] dly_q   [STAGES];
    logic signed [ACC_W-1:0] dly_d   [STAGES];
    logic signed [ACC_W-1:0] comb_v  [STAGES];

    always_comb begin
      comb_v[0] = integ_q[STAGES-1] - dly_q[0];
      for (int k = 1; k < STAGES; k++) comb_v[k] = comb_v[k-1] - dly_q[k];
    end

    always_comb begin
      integ_d = integ_q;
      dly_d   = dly_q;
      if (bypass) begin
        for (int k = 0; k < STAGES; k++) begin
          integ_d[k] = '0;
          dly_d[k]   = '0;
        end
      end else if (en && in_v) begin
        integ_d[0] = integ_q[0] + ACC_W'(lane_in[ln]);
        for (int k = 1; k < STAGES; k++) integ_d[k] = integ_q[k] + integ_q[k-1];
        if (hit) begin
          dly_d[0] = integ_q[STAGES-1];
          for (int k = 1; k < STAGES; k++) dly_d[k] = comb_v[k-1];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < STAGES; k++) begin
          integ_q[k] <= '0;
          dly_q[k]   <= '0;
        end
      end else begin
        integ_q <= integ_d;
        dly_q   <= dly_d;
      end
    end

    ddc_quant #(
      .IN_W  (ACC_W),
      .OUT_W (SMP_W),
      .SH_W  (SH_W),
      .MAX_SH(SH_MAX)
    ) u_quant (
      .din  (comb_v[STAGES-1]),
      .shift(cic_shift),
      .dout (lane_out[ln])
    );
  end

  logic                    ov_d;
  logic signed [SMP_W-1:0] oi_d, oq_d;

  always_comb begin
    ov_d = out_v;
    oi_d = out_i;
    oq_d = out_q;
    if (en) begin
      if (bypass) begin
        ov_d = in_v;
        if (in_v) begin
          oi_d = in_i;
          oq_d = in_q;
        end
      end else begin
        ov_d = in_v && hit;
        if (in_v && hit) begin
          oi_d = lane_out[0];
          oq_d = lane_out[1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_i <= '0;
      out_q <= '0;
    end else begin
      out_v <= ov_d;
      out_i <= oi_d;
      out_q <= oq_d;
    end
  end

  AST_BYP_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (cnt_q == '0)); // R8
  AST_NO_OUT_WITHOUT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !in_v) |=> !out_v); // R9
  AST_DEC_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_v && !bypass && (cnt_q == '0) && (dec_eff > DEC_W'(1))) |=> !out_v); // R9
endmodule

// File: rtl/ddc_core.sv
module ddc_core
  import ddc_pkg::*;
#(
  parameter int PH_W    = 32,
  parameter int LUT_AW  = 6,
  parameter int STAGES  = 3,
  parameter int DEC_MAX = 1000,
  parameter int PSH_MAX = 16,
  parameter int CSH_MAX = 30,
  parameter int SH_W    = 5,
  localparam int DEC_W  = $clog2(DEC_MAX+1),
  localparam int BUS_W  = 2*SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  pinc,
  input  logic             pinc_we,
  input  logic [1:0]       src_sel,
  input  logic             cic_bypass,
  input  logic [SH_W-1:0]  prod_shift,
  input  logic [SH_W-1:0]  cic_shift,
  input  logic [DEC_W-1:0] dec_ratio,
  input  logic             s_tvalid,
  output logic             s_tready,
  input  logic [BUS_W-1:0] s_tdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic [BUS_W-1:0] m_tdata
);
  localparam int PROD_W = 2*SMP_W + 1;

  logic adv, accept;
  assign adv      = !m_tvalid || m_tready;
  assign s_tready = adv;
  assign accept   = s_tvalid && adv;

  cplx_t in_w;
  assign in_w = cplx_t'(s_tdata);

  logic signed [SMP_W-1:0] lo_c, lo_s;

  ddc_nco #(
    .PH_W  (PH_W),
    .LUT_AW(LUT_AW),
    .AMP_W (SMP_W)
  ) u_nco (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (accept),
    .pinc   (pinc),
    .pinc_we(pinc_we),
    .cos_o  (lo_c),
    .sin_o  (lo_s)
  );

  // Stage 1: sample with its oscillator value
  logic  s1_v_q, s1_v_d;
  cplx_t s1_x_q, s1_x_d, s1_lo_q, s1_lo_d;
  // Stage 2: full-precision product
  logic  s2_v_q, s2_v_d;
  cplx_t s2_x_q, s2_x_d, s2_lo_q, s2_lo_d;
  logic signed [PROD_W-1:0] s2_re_q, s2_re_d, s2_im_q, s2_im_d;
  // Stage 3: selected source
  logic  s3_v_q, s3_v_d;
  cplx_t s3_x_q, s3_x_d;

  logic signed [PROD_W-1:0] mix_re, mix_im;
  logic signed [SMP_W-1:0]  pq_re, pq_im;

  ddc_mixer #(.IW(SMP_W), .CW(SMP_W), .PW(PROD_W)) u_mix (
    .in_i(s1_x_q.i),
    .in_q(s1_x_q.q),
    .lo_c(s1_lo_q.i),
    .lo_s(s1_lo_q.q),
    .re  (mix_re),
    .im  (mix_im)
  );

  ddc_quant #(.IN_W(PROD_W), .OUT_W(SMP_W), .SH_W(SH_W), .MAX_SH(PSH_MAX)) u_pq_re (
    .din(s2_re_q), .shift(prod_shift), .dout(pq_re)
  );
  ddc_quant #(.IN_W(PROD_W), .OUT_W(SMP_W), .SH_W(SH_W), .MAX_SH(PSH_MAX)) u_pq_im (
    .din(s2_im_q), .shift(prod_shift), .dout(pq_im)
  );

  src_sel_e src;
  assign src = src_sel_e'(src_sel);

  always_comb begin
    s1_v_d = s1_v_q;  s1_x_d = s1_x_q;  s1_lo_d = s1_lo_q;
    s2_v_d = s2_v_q;  s2_x_d = s2_x_q;  s2_lo_d = s2_lo_q;
    s2_re_d = s2_re_q; s2_im_d = s2_im_q;
    s3_v_d = s3_v_q;  s3_x_d = s3_x_q;
    if (adv) begin
      s1_v_d = s_tvalid;
      if (s_tvalid) begin
        s1_x_d  = in_w;
        s1_lo_d = '{q: lo_s, i: lo_c};
      end
      s2_v_d = s1_v_q;
      if (s1_v_q) begin
        s2_x_d  = s1_x_q;
        s2_lo_d = s1_lo_q;
        s2_re_d = mix_re;
        s2_im_d = mix_im;
      end
      s3_v_d = s2_v_q;
      if (s2_v_q) begin
        case (src)
          SRC_PRODUCT: s3_x_d = '{q: pq_im, i: pq_re};
          SRC_NCO:     s3_x_d = s2_lo_q;
          default:     s3_x_d = s2_x_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0; s1_x_q <= '0; s1_lo_q <= '0;
      s2_v_q <= 1'b0; s2_x_q <= '0; s2_lo_q <= '0;
      s2_re_q <= '0;  s2_im_q <= '0;
      s3_v_q <= 1'b0; s3_x_q <= '0;
    end else begin
      s1_v_q <= s1_v_d; s1_x_q <= s1_x_d; s1_lo_q <= s1_lo_d;
      s2_v_q <= s2_v_d; s2_x_q <= s2_x_d; s2_lo_q <= s2_lo_d;
      s2_re_q <= s2_re_d; s2_im_q <= s2_im_d;
      s3_v_q <= s3_v_d; s3_x_q <= s3_x_d;
    end
  end

  logic signed [SMP_W-1:0] out_i, out_q;

  ddc_cic #(
    .SMP_W  (SMP_W),
    .STAGES (STAGES),
    .DEC_MIN(2),
    .DEC_MAX(DEC_MAX),
    .SH_MAX (CSH_MAX),
    .SH_W   (SH_W),
    .DEC_W  (DEC_W)
  ) u_cic (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (adv),
    .bypass   (cic_bypass),
    .dec_ratio(dec_ratio),
    .cic_shift(cic_shift),
    .in_v     (s3_v_q),
    .in_i     (s3_x_q.i),
    .in_q     (s3_x_q.q),
    .out_v    (m_tvalid),
    .out_i    (out_i),
    .out_q    (out_q)
  );

  assign m_tdata = {out_q, out_i};

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata))); // R11
endmodule

// File: tb/ddc_core_tb.sv
`timescale 1ns/1ps
module ddc_core_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pinc;
  logic        pinc_we;
  logic [1:0]  src_sel;
  logic        cic_bypass;
  logic [4:0]  prod_shift;
  logic [4:0]  cic_shift;
  logic [9:0]  dec_ratio;
  logic        s_tvalid;
  logic        s_tready;
  logic [31:0] s_tdata;
  logic        m_tvalid;
  logic        m_tready;
  logic [31:0] m_tdata;

  always #10 clk = ~clk;

  ddc_core u_dut (
    .clk(clk), .rst_n(rst_n), .pinc(pinc), .pinc_we(pinc_we),
    .src_sel(src_sel), .cic_bypass(cic_bypass), .prod_shift(prod_shift),
    .cic_shift(cic_shift), .dec_ratio(dec_ratio),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [31:0] rxq [$];

  always @(negedge clk)
    if (rst_n && m_tvalid && m_tready) rxq.push_back(m_tdata);

  typedef struct packed {
    logic [1:0]  src;
    logic [4:0]  sh;
    logic [15:0] ii;
    logic [15:0] qi;
    logic [15:0] ei;
    logic [15:0] eq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 5'd0,  16'(1234),   16'(-5678), 16'(1234),   16'(-5678)},  // R2
    '{2'd3, 5'd0,  16'(-1),     16'(32767), 16'(-1),     16'(32767)},  // R2
    '{2'd1, 5'd0,  16'(5),      16'(5),     16'(32767),  16'(0)},      // R3
    '{2'd0, 5'd15, 16'(1000),   16'(-1000), 16'(999),    16'(-1000)},  // R6
    '{2'd0, 5'd0,  16'(1000),   16'(-1000), 16'(32767),  16'(-32768)}, // R7
    '{2'd0, 5'd16, 16'(1000),   16'(-1000), 16'(499),    16'(-500)},   // R7
    '{2'd0, 5'd31, 16'(1000),   16'(-1000), 16'(499),    16'(-500)},   // R7
    '{2'd0, 5'd15, 16'(-32768), 16'(32767), 16'(-32767), 16'(32766)},  // R6
    '{2'd0, 5'd14, 16'(20000),  16'(-20000),16'(32767),  16'(-32768)}  // R7
  };

  function automatic logic [31:0] pk(input int i, input int q);
    return {16'(q), 16'(i)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send(input int i, input int q);
    s_tvalid = 1'b1;
    s_tdata  = pk(i, q);
    do @(negedge clk); while (!s_tready);
    @(posedge clk);
    #2;
    s_tvalid = 1'b0;
  endtask

  task automatic drain();
    tick(12);
  endtask

  task automatic cic_run(input string tag, input int d, input int sh, input int n,
                         input int xi, input int xq, input int exp_n,
                         input int ei, input int eq, input int nlast);
    cic_bypass = 1'b1;
    tick(2);
    dec_ratio  = 10'(d);
    cic_shift  = 5'(sh);
    cic_bypass = 1'b0;
    tick(1);
    rxq.delete();
    for (int k = 0; k < n; k++) send(xi, xq);
    drain();
    chk({tag, " count R9"}, 32'(rxq.size()), 32'(exp_n));
    for (int k = 0; k < nlast; k++)
      if (rxq.size() > k) chk({tag, " value R10"}, rxq[rxq.size()-1-k], pk(ei, eq));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    rst_n = 1'b0; pinc = '0; pinc_we = 1'b0; src_sel = 2'd2; cic_bypass = 1'b1;
    prod_shift = '0; cic_shift = '0; dec_ratio = 10'd2;
    s_tvalid = 1'b0; s_tdata = '0; m_tready = 1'b1;
    tick(3);
    @(negedge clk);
    chk("R1 tvalid in reset", 32'(m_tvalid), 32'd0);
    chk("R1 tready in reset", 32'(s_tready), 32'd1);
    rst_n = 1'b1;
    tick(2);
    @(negedge clk);
    chk("R1 tvalid after reset", 32'(m_tvalid), 32'd0);
    #12;

    // Table of single-sample vectors, oscillator at phase 0
    for (int v = 0; v < NV; v++) begin
      src_sel    = VEC[v].src;
      prod_shift = VEC[v].sh;
      rxq.delete();
      send(int'($signed(VEC[v].ii)), int'($signed(VEC[v].qi)));
      drain();
      chk($sformatf("R8 one-out vector %0d", v), 32'(rxq.size()), 32'd1);
      if (rxq.size() > 0)
        chk($sformatf("R2/R3/R6/R7 vector %0d", v), rxq[0], {VEC[v].eq, VEC[v].ei});
    end

    // Increment write strobe
    src_sel = 2'd1;
    pinc    = 32'h4000_0000;
    rxq.delete();
    send(0, 0);
    pinc_we = 1'b1;
    send(0, 0);
    drain();
    chk("R5 no load without strobe fall", rxq[0], pk(32767, 0));
    chk("R5 no load while strobe high", rxq[1], pk(32767, 0));
    pinc_we = 1'b0;
    tick(1);
    rxq.delete();
    for (int k = 0; k < 5; k++) send(0, 0);
    drain();
    chk("R4 phase count", 32'(rxq.size()), 32'd5);
    chk("R3 quarter 0", rxq[0], pk(32767, 0));
    chk("R3 quarter 1", rxq[1], pk(0, 32767));
    chk("R3 quarter 2", rxq[2], pk(-32767, 0));
    chk("R3 quarter 3", rxq[3], pk(0, -32767));
    chk("R4 wrap", rxq[4], pk(32767, 0));

    // Mixer at quarter-turn phase
    src_sel = 2'd0;
    prod_shift = 5'd15;
    rxq.delete();
    send(1000, 0);
    drain();
    chk("R6 mixer quarter phase", rxq[0], pk(0, -1000));

    pinc = '0;
    pinc_we = 1'b1; tick(1); pinc_we = 1'b0; tick(2);

    // CIC runs on the input path
    src_sel = 2'd2;
    cic_run("D2",    2,    3,  20,   100,   -50,  10,   100,   -50, 5);
    cic_run("D5",    5,    7,  40,   100,   -50,   8,    97,   -49, 3);
    cic_run("D1000", 1000, 31, 5000, 1000,  -1000, 5,   931,  -932, 1);
    cic_run("Dsat",  1000, 0,  2000, 1000,  -1000, 2, 32767, -32768, 1);
    cic_run("Dlow",  1,    3,  10,   100,   -50,   5,   100,   -50, 2);

    // Backpressure
    cic_bypass = 1'b1;
    tick(2);
    rxq.delete();
    m_tready = 1'b0;
    send(11, 22);
    send(33, 44);
    tick(8);
    @(negedge clk);
    chk("R11 held valid", 32'(m_tvalid), 32'd1);
    chk("R11 held data", m_tdata, pk(11, 22));
    chk("R11 ready low", 32'(s_tready), 32'd0);
    tick(3);
    @(negedge clk);
    chk("R11 still held", m_tdata, pk(11, 22));
    #12;
    m_tready = 1'b1;
    drain();
    chk("R11 count", 32'(rxq.size()), 32'd2);
    if (rxq.size() == 2) begin
      chk("R11 first", rxq[0], pk(11, 22));
      chk("R11 second", rxq[1], pk(33, 44));
    end

    report();
  end
endmodule